// File: doc/BRIEF.md
# Planar Display Memory Write Merger

This block forms the four bit-plane bytes that a CPU write stores into planar display memory. It holds one data latch per plane, loaded from a memory read by a strobe, and combines the latched bytes with the CPU data byte under one of four write modes. Register-style inputs set the write mode, a right-rotate count, a 4-bit set/reset colour with a per-plane enable, a per-bit write mask and a 2-bit logical function.

The plane outputs are a combinational function of the current inputs and the latches. The memory controller samples them during a write and stores them at the addressed location. Plane write enables, addressing and the memory array are outside this block. A read followed by a write in the latch-copy mode moves all eight pixels of a byte in two accesses. The other modes expand a colour, apply a rotated byte, or fill with a masked pattern.

Top module: `vga_plane_writer`

## Requirements
- R1: After reset, all four plane latches hold zero, so write mode 1 outputs all zeros.
- R2: On a clock edge with `latchLoad` high, the latches capture `memRdData`. Plane p uses bits [8p+7:8p].
- R3: The latches change only on a `latchLoad` edge. Writes and other input changes leave them unchanged.
- R4: Write mode 1 (`wrMode`=1) outputs each plane's latch byte unchanged. It ignores CPU data, mask, function and colour.
- R5: In write mode 0, the CPU byte is rotated right by `rotCount` (0 to 7) before it is combined with the latches.
- R6: In write mode 0, plane p uses `setResetColor[p]` replicated to 8 bits in place of the rotated data when `setResetEnable[p]` is 1.
- R7: In write mode 2, plane p uses CPU data bit p replicated across all 8 bit positions.
- R8: In write mode 3, the select byte is (CPU byte rotated right by `rotCount`) AND `bitMask`. Where a select bit is 1, plane p takes `setResetColor[p]`; where it is 0, the plane keeps its latch bit.
- R9: In modes 0, 2 and 3, the source is combined with the latch by `logicFunc`: 0 replace, 1 AND, 2 OR, 3 XOR.
- R10: In modes 0 and 2, each `bitMask` bit that is 0 makes that bit position of every plane take the latch value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| latchLoad | input | 1 | Capture memRdData into the latches |
| memRdData | input | 32 | Four plane bytes read from memory, plane p at [8p+7:8p] |
| cpuData | input | 8 | CPU write data byte |
| wrMode | input | 2 | Write mode 0 to 3 |
| rotCount | input | 3 | Right-rotate count for the CPU byte |
| setResetColor | input | 4 | Set/reset colour, one bit per plane |
| setResetEnable | input | 4 | Per-plane set/reset substitution for mode 0 |
| bitMask | input | 8 | Per-bit write mask |
| logicFunc | input | 2 | Logical function: replace, AND, OR, XOR |
| planeData | output | 32 | Plane bytes to store, plane p at [8p+7:8p] |

## Verification
The latches are loaded with four different bytes, so a plane-swap or bit-order fault shows up in one plane and no other. Rotate counts of 1, 4 and 7 expose a rotation in the wrong direction or by the wrong amount: the byte would land shifted the other way. A mode 0 vector with mixed set/reset enables catches a design that substitutes the colour on every plane, or on the wrong ones. A partial mask with a non-zero source shows whether masked positions fall back to the latch or leak ALU output. Rewrites and changes of memRdData without the strobe, followed by a mode 1 readout, would expose latches that update on a write.

// File: rtl/vga_plane_pkg.sv
package vga_plane_pkg;
  parameter int NUM_PLANES = 4;
  parameter int PLANE_W    = 8;

  typedef enum logic [1:0] {
    WM_ROTATE  = 2'd0,
    WM_COPY    = 2'd1,
    WM_EXPAND  = 2'd2,
    WM_PATTERN = 2'd3
  } wrMode_e;

  typedef enum logic [1:0] {
    LF_REPLACE = 2'd0,
    LF_AND     = 2'd1,
    LF_OR      = 2'd2,
    LF_XOR     = 2'd3
  } logicFunc_e;

  typedef struct packed {
    logic                  copyLatch;
    logic                  expandCpu;
    logic                  patternSel;
    logic [NUM_PLANES-1:0] useSetReset;
  } ctlStrobes_t;
endpackage

// File: rtl/vga_plane_ctrl.sv
module vga_plane_ctrl
  import vga_plane_pkg::*;
(
  input  logic [1:0]            wrMode,
  input  logic [NUM_PLANES-1:0] setResetEnable,
  output ctlStrobes_t           strobes
);
  wrMode_e modeSel;

  always_comb begin
    modeSel = wrMode_e'(wrMode);
    strobes = '0;
    unique case (modeSel)
      WM_ROTATE:  strobes.useSetReset = setResetEnable;
      WM_COPY:    strobes.copyLatch   = 1'b1;
      WM_EXPAND:  strobes.expandCpu   = 1'b1;
      WM_PATTERN: begin
        strobes.patternSel  = 1'b1;
        strobes.useSetReset = '1;
      end
      default:    strobes = '0;
    endcase
  end
endmodule

// File: rtl/vga_plane_latch.sv
module vga_plane_latch
  import vga_plane_pkg::*;
#(
  parameter int BUS_W = NUM_PLANES * PLANE_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             latchLoad,
  input  logic [BUS_W-1:0] memRdData,
  output logic [BUS_W-1:0] latchQ
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         latchQ <= '0;
    else if (latchLoad) latchQ <= memRdData;
  end

  // R2: a load strobe captures the read data
  assert_latch_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
    latchLoad |=> (latchQ == $past(memRdData)));

  // R3: without a strobe the latches hold
  assert_latch_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !latchLoad |=> $stable(latchQ));
endmodule

// File: rtl/vga_plane_datapath.sv
module vga_plane_datapath
  import vga_plane_pkg::*;
#(
  parameter int ROT_W = $clog2(PLANE_W),
  parameter int BUS_W = NUM_PLANES * PLANE_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  ctlStrobes_t           strobes,
  input  logic [PLANE_W-1:0]    cpuData,
  input  logic [ROT_W-1:0]      rotCount,
  input  logic [NUM_PLANES-1:0] setResetColor,
  input  logic [PLANE_W-1:0]    bitMask,
  input  logic [1:0]            logicFunc,
  input  logic [BUS_W-1:0]      latchQ,
  output logic [BUS_W-1:0]      planeData
);
  logic [2*PLANE_W-1:0] rotWide;
  logic [PLANE_W-1:0]   rotated;
  logic [PLANE_W-1:0]   mergeSel;

  always_comb begin
    rotWide  = {cpuData, cpuData} >> rotCount;
    rotated  = rotWide[PLANE_W-1:0];
    mergeSel = strobes.patternSel ? (rotated & bitMask) : bitMask;
  end

  for (genvar p = 0; p < NUM_PLANES; p++) begin : g_plane
    logic [PLANE_W-1:0] latchByte;
    logic [PLANE_W-1:0] srcByte;
    logic [PLANE_W-1:0] aluByte;
    logic [PLANE_W-1:0] outByte;

    always_comb begin
      latchByte = latchQ[p*PLANE_W +: PLANE_W];
      if (strobes.useSetReset[p])  srcByte = {PLANE_W{setResetColor[p]}};
      else if (strobes.expandCpu)  srcByte = {PLANE_W{cpuData[p]}};
      else                         srcByte = rotated;
      unique case (logicFunc_e'(logicFunc))
        LF_AND:  aluByte = srcByte & latchByte;
        LF_OR:   aluByte = srcByte | latchByte;
        LF_XOR:  aluByte = srcByte ^ latchByte;
        default: aluByte = srcByte;
      endcase
      if (strobes.copyLatch) outByte = latchByte;
      else                   outByte = (aluByte & mergeSel) | (latchByte & ~mergeSel);
      planeData[p*PLANE_W +: PLANE_W] = outByte;
    end
  end

  // R4: copy mode returns the latches untouched
  assert_copy_latch_R4: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.copyLatch |-> (planeData == latchQ));

  // R10: masked-off bit positions come from the latch
  assert_mask_keeps_latch_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!strobes.copyLatch && !strobes.patternSel) |->
      ((planeData & ~{NUM_PLANES{bitMask}}) == (latchQ & ~{NUM_PLANES{bitMask}})));

  // R8: in pattern mode, bits outside the mask never change
  assert_pattern_masked_R8: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.patternSel |->
      ((planeData & ~{NUM_PLANES{bitMask}}) == (latchQ & ~{NUM_PLANES{bitMask}})));

  // only one mode strobe at a time
  assert_one_mode_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({strobes.copyLatch, strobes.expandCpu, strobes.patternSel}));
endmodule

// File: rtl/vga_plane_writer.sv
module vga_plane_writer
  import vga_plane_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        latchLoad,
  input  logic [31:0] memRdData,
  input  logic [7:0]  cpuData,
  input  logic [1:0]  wrMode,
  input  logic [2:0]  rotCount,
  input  logic [3:0]  setResetColor,
  input  logic [3:0]  setResetEnable,
  input  logic [7:0]  bitMask,
  input  logic [1:0]  logicFunc,
  output logic [31:0] planeData
);
  ctlStrobes_t strobes;
  logic [31:0] latchQ;

  vga_plane_ctrl i_ctrl (
    .wrMode         (wrMode),
    .setResetEnable (setResetEnable),
    .strobes        (strobes)
  );

  vga_plane_latch i_latch (
    .clk       (clk),
    .rst_n     (rst_n),
    .latchLoad (latchLoad),
    .memRdData (memRdData),
    .latchQ    (latchQ)
  );

  vga_plane_datapath i_dp (
    .clk           (clk),
    .rst_n         (rst_n),
    .strobes       (strobes),
    .cpuData       (cpuData),
    .rotCount      (rotCount),
    .setResetColor (setResetColor),
    .bitMask       (bitMask),
    .logicFunc     (logicFunc),
    .latchQ        (latchQ),
    .planeData     (planeData)
  );
endmodule

// File: tb/test_vga_plane_writer.sv
module test_vga_plane_writer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        latchLoad = 1'b0;
  logic [31:0] memRdData = '0;
  logic [7:0]  cpuData = '0;
  logic [1:0]  wrMode = 2'd1;
  logic [2:0]  rotCount = '0;
  logic [3:0]  setResetColor = '0;
  logic [3:0]  setResetEnable = '0;
  logic [7:0]  bitMask = 8'hFF;
  logic [1:0]  logicFunc = '0;
  logic [31:0] planeData;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  vga_plane_writer i_vga_plane_writer (
    .clk(clk), .rst_n(rst_n), .latchLoad(latchLoad), .memRdData(memRdData),
    .cpuData(cpuData), .wrMode(wrMode), .rotCount(rotCount),
    .setResetColor(setResetColor), .setResetEnable(setResetEnable),
    .bitMask(bitMask), .logicFunc(logicFunc), .planeData(planeData)
  );

  // {mode, rot, color, srEnable, mask, func, cpu, expected}, latches = F0CCAA0F
  localparam logic [62:0] VECS [12] = '{
    {2'd1, 3'd0, 4'h0, 4'h0, 8'hFF, 2'd0, 8'h00, 32'hF0CCAA0F}, // R4
    {2'd0, 3'd0, 4'h0, 4'h0, 8'hFF, 2'd0, 8'h5A, 32'h5A5A5A5A}, // R5 R9 replace
    {2'd0, 3'd4, 4'h0, 4'h0, 8'hFF, 2'd1, 8'h5A, 32'hA084A005}, // R5 R9 AND
    {2'd0, 3'd0, 4'h1, 4'h5, 8'hFF, 2'd0, 8'h3C, 32'h3C003CFF}, // R6
    {2'd0, 3'd0, 4'h0, 4'h0, 8'h0F, 2'd0, 8'h00, 32'hF0C0A000}, // R10
    {2'd2, 3'd0, 4'h0, 4'h0, 8'hFF, 2'd0, 8'h05, 32'h00FF00FF}, // R7
    {2'd2, 3'd0, 4'h0, 4'h0, 8'hFF, 2'd3, 8'h0F, 32'h0F3355F0}, // R7 R9 XOR
    {2'd2, 3'd0, 4'h0, 4'h0, 8'h3C, 2'd2, 8'h0F, 32'hFCFCBE3F}, // R9 OR R10
    {2'd3, 3'd1, 4'hA, 4'h0, 8'hFF, 2'd0, 8'h81, 32'hF00CEA0F}, // R8
    {2'd3, 3'd0, 4'hF, 4'h0, 8'h0F, 2'd0, 8'hFF, 32'hFFCFAF0F}, // R8 mask
    {2'd0, 3'd7, 4'h0, 4'h0, 8'hFF, 2'd2, 8'h01, 32'hF2CEAA0F}, // R5 rot7
    {2'd1, 3'd5, 4'hF, 4'hF, 8'h00, 2'd3, 8'hFF, 32'hF0CCAA0F}  // R4 ignores
  };

  task automatic check(input string req, input logic [31:0] exp);
    testsRun++;
    if (planeData !== exp) begin
      testsFailed++;
      $display("FAIL %s: planeData=%h expected=%h", req, planeData, exp);
    end
  endtask

  task automatic showLatches();
    wrMode = 2'd1;
    #1;
  endtask

  task automatic loadLatches(input logic [31:0] val);
    @(negedge clk);
    memRdData = val;
    latchLoad = 1'b1;
    @(negedge clk);
    latchLoad = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    showLatches();
    check("R1 reset latches", 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    showLatches();
    check("R1 after release", 32'h0);

    loadLatches(32'hF0CCAA0F);
    showLatches();
    check("R2 load", 32'hF0CCAA0F);

    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      {wrMode, rotCount, setResetColor, setResetEnable, bitMask, logicFunc, cpuData} = VECS[i][62:32];
      #1;
      check($sformatf("vector %0d R4-R10 table", i), VECS[i][31:0]);
    end

    @(negedge clk);
    memRdData = 32'hDEADBEEF;
    wrMode = 2'd3; cpuData = 8'hFF; bitMask = 8'hFF; setResetColor = 4'hF;
    repeat (3) @(negedge clk);
    showLatches();
    check("R3 latches hold after writes", 32'hF0CCAA0F);

    loadLatches(32'h12345678);
    showLatches();
    check("R2 reload", 32'h12345678);

    @(negedge clk);
    wrMode = 2'd0; rotCount = 3'd0; setResetEnable = 4'h0;
    bitMask = 8'h00; logicFunc = 2'd3; cpuData = 8'hFF;
    #1;
    check("R10 zero mask keeps latch", 32'h12345678);

    @(negedge clk);
    wrMode = 2'd0; rotCount = 3'd1; bitMask = 8'hFF; logicFunc = 2'd0; cpuData = 8'h01;
    #1;
    check("R5 rot1 wraps low bit", 32'h80808080);

    @(negedge clk);
    rst_n = 1'b0;
    #1;
    showLatches();
    check("R1 reset clears latches", 32'h0);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    #100000;
    if (!finished) begin
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end
endmodule